// File: doc/BRIEF.md
# Processor Exception Cause Generator

This block watches a processor's execute stage, one operation per cycle. It decides whether that operation should raise a hardware exception. It handles four kinds of operation: divides, data loads, data stores and instruction fetches. From the operands and the access details it detects four causes: a zero divisor, a misaligned data access, a data address outside the stack window, and a bus error on a fetch or a data access. For the chosen cause it writes an exception status word and an exception address register. It also keeps a sticky divide-by-zero status bit that the machine status register can expose.

Each cause is gated in its own way. A misaligned access is always recorded, but it only raises the strobe when exceptions are enabled. A stack violation always raises the strobe. A divide by zero raises the strobe only when exceptions are enabled and its configuration bit is set. A bus error is ignored completely while exceptions are disabled. At most one cause is reported per operation. Vectoring to a handler and flushing the pipeline are done by the surrounding core, which uses the strobe.

Top module: `exc_cause_gen`

## Requirements
- R1: After reset, `exc_strobe`, `esr`, `ear` and `div_zero` are all zero.
- R2: A divide (`op_kind` 0) with a zero divisor sets `div_zero`, which stays set across the non-divide operations that follow. It writes `esr` = 5 and pulses `exc_strobe` only when `msr_ee` and `cfg_div_exc` are both 1. It never changes `ear`.
- R3: A divide with a nonzero divisor clears `div_zero` and raises no exception.
- R4: Only loads (`op_kind` 1) and stores (`op_kind` 2) are tested for alignment and stack bounds. The alignment mask is 0 for size code 0 (byte), 1 for size code 1 (halfword) and 3 for size code 2 (word). An access is misaligned when the low address bits ANDed with the mask are nonzero. Aligned accesses, and fetches (`op_kind` 3) with no bus error, change nothing.
- R5: A misaligned access sets `ear` to the address. It writes `esr` with cause code 1 in bits 4:0, the destination register in bits 9:5, bit 10 = 1 for a store and bit 11 = 1 for a word access. All higher bits are zero.
- R6: The misaligned-access `esr`/`ear` update happens whatever the state of `msr_ee`. `exc_strobe` follows `msr_ee`.
- R7: A load or store whose address is unsigned below `stk_lo` or above `stk_hi` sets `ear` to the address and `esr` to 7, and always pulses `exc_strobe`. Addresses equal to either bound are legal.
- R8: A fetch, load or store with `bus_err` = 1 while `msr_ee` = 0 leaves `esr`, `ear` and `div_zero` unchanged and raises no strobe, even if the access is also misaligned or out of bounds.
- R9: With `msr_ee` = 1, a bus error always sets `ear` to the address. A fetch writes `esr` = 3 and pulses the strobe only if `cfg_ibus_exc` = 1. A load or store writes `esr` = 4 and pulses the strobe only if `cfg_dbus_exc` = 1.
- R10: Cause priority is bus error, then misalignment, then stack violation.
- R11: Results appear on the clock edge that samples the operation. `exc_strobe` is a one-cycle pulse. With `op_valid` low, nothing changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_kind | input | 2 | 0 divide, 1 load, 2 store, 3 instruction fetch |
| addr | input | AW | Access address |
| divisor | input | DW | Divisor operand |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word |
| dest_reg | input | RW | Destination register index |
| stk_lo | input | AW | Lowest legal stack address |
| stk_hi | input | AW | Highest legal stack address |
| bus_err | input | 1 | Bus reported an error for this access |
| msr_ee | input | 1 | Global exception enable |
| cfg_div_exc | input | 1 | Divide-by-zero exception configured |
| cfg_ibus_exc | input | 1 | Instruction bus exception configured |
| cfg_dbus_exc | input | 1 | Data bus exception configured |
| exc_strobe | output | 1 | One-cycle exception pulse |
| esr | output | EW | Exception status word |
| ear | output | AW | Exception address |
| div_zero | output | 1 | Sticky divide-by-zero status |

## Verification
Every result of this block is registered once. An operation presented before a rising edge shows its strobe, status word, address and divide flag right after that edge, and the strobe is gone one edge later. The bench drives inputs on the falling edge and samples all four outputs one nanosecond after the following rising edge. It then idles one cycle and samples again, to confirm the strobe has dropped. The vector table is ordered so that each row's expected register contents include what earlier rows left behind. This covers the cases that must leave state untouched.

// File: rtl/exc_cause_gen.sv
module exc_cause_gen #(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5,
  parameter int EW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [1:0]    op_kind,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] divisor,
  input  logic [1:0]    acc_size,
  input  logic [RW-1:0] dest_reg,
  input  logic [AW-1:0] stk_lo,
  input  logic [AW-1:0] stk_hi,
  input  logic          bus_err,
  input  logic          msr_ee,
  input  logic          cfg_div_exc,
  input  logic          cfg_ibus_exc,
  input  logic          cfg_dbus_exc,
  output logic          exc_strobe,
  output logic [EW-1:0] esr,
  output logic [AW-1:0] ear,
  output logic          div_zero
);
  localparam int CW     = 5;
  localparam int WR_BIT = CW + RW;
  localparam int WD_BIT = CW + RW + 1;
  localparam logic [CW-1:0] C_ALIGN = CW'(1);
  localparam logic [CW-1:0] C_IBUS  = CW'(3);
  localparam logic [CW-1:0] C_DBUS  = CW'(4);
  localparam logic [CW-1:0] C_DIVZ  = CW'(5);
  localparam logic [CW-1:0] C_STACK = CW'(7);

  logic is_div, is_store, is_fetch, is_data;
  logic [1:0] amask;
  logic misal, stk_bad, bus_hit, div_by_0;
  logic [EW-1:0] align_word;

  assign is_div   = op_kind == 2'd0;
  assign is_store = op_kind == 2'd2;
  assign is_fetch = op_kind == 2'd3;
  assign is_data  = op_kind == 2'd1 || is_store;
  assign amask    = acc_size == 2'd2 ? 2'b11 : (acc_size == 2'd1 ? 2'b01 : 2'b00);
  assign misal    = is_data && |(addr[1:0] & amask);
  assign stk_bad  = is_data && (addr < stk_lo || addr > stk_hi);
  assign bus_hit  = bus_err && !is_div;
  assign div_by_0 = divisor == '0;

  always_comb begin
    align_word                     = '0;
    align_word[CW-1:0]             = C_ALIGN;
    align_word[CW +: RW]           = dest_reg;
    align_word[WR_BIT]             = is_store;
    align_word[WD_BIT]             = acc_size == 2'd2;
  end

  logic          stb_n, dz_n;
  logic [EW-1:0] esr_n;
  logic [AW-1:0] ear_n;

  always_comb begin
    stb_n = 1'b0;
    esr_n = esr;
    ear_n = ear;
    dz_n  = div_zero;
    if (op_valid) begin
      if (bus_hit) begin
        if (msr_ee) begin
          ear_n = addr;
          if (is_fetch ? cfg_ibus_exc : cfg_dbus_exc) begin
            esr_n = EW'(is_fetch ? C_IBUS : C_DBUS);
            stb_n = 1'b1;
          end
        end
      end else if (misal) begin
        ear_n = addr;
        esr_n = align_word;
        stb_n = msr_ee;
      end else if (stk_bad) begin
        ear_n = addr;
        esr_n = EW'(C_STACK);
        stb_n = 1'b1;
      end else if (is_div) begin
        dz_n = div_by_0;
        if (div_by_0 && msr_ee && cfg_div_exc) begin
          esr_n = EW'(C_DIVZ);
          stb_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exc_strobe <= 1'b0;
      esr        <= '0;
      ear        <= '0;
      div_zero   <= 1'b0;
    end else begin
      exc_strobe <= stb_n;
      esr        <= esr_n;
      ear        <= ear_n;
      div_zero   <= dz_n;
    end
  end

  a_r2_zero_divisor_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'd0 && divisor == '0 |=> div_zero);

  a_r3_nonzero_divisor_clears: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_kind == 2'd0 && divisor != '0 |=> !div_zero && !exc_strobe);

  a_r6_misaligned_recorded: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_data && !bus_err && misal
    |=> esr[CW-1:0] == C_ALIGN && ear == $past(addr) && exc_strobe == $past(msr_ee));

  a_r7_stack_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_data && !bus_err && !misal && stk_bad
    |=> exc_strobe && esr[CW-1:0] == C_STACK && ear == $past(addr));

  a_r8_bus_quiet_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && bus_err && op_kind != 2'd0 && !msr_ee
    |=> !exc_strobe && $stable(esr) && $stable(ear) && $stable(div_zero));

  a_r11_idle_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !exc_strobe && $stable(esr) && $stable(ear) && $stable(div_zero));

endmodule

// File: tb/test_exc_cause_gen.sv
module test_exc_cause_gen;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, op_valid, bus_err, msr_ee, cfg_div_exc, cfg_ibus_exc, cfg_dbus_exc;
  logic [1:0] op_kind, acc_size;
  logic [31:0] addr, divisor, stk_lo, stk_hi;
  logic [4:0] dest_reg;
  logic exc_strobe, div_zero;
  logic [31:0] esr, ear;

  exc_cause_gen i_exc_cause_gen (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_kind(op_kind), .addr(addr),
    .divisor(divisor), .acc_size(acc_size), .dest_reg(dest_reg), .stk_lo(stk_lo),
    .stk_hi(stk_hi), .bus_err(bus_err), .msr_ee(msr_ee), .cfg_div_exc(cfg_div_exc),
    .cfg_ibus_exc(cfg_ibus_exc), .cfg_dbus_exc(cfg_dbus_exc), .exc_strobe(exc_strobe),
    .esr(esr), .ear(ear), .div_zero(div_zero)
  );

  typedef struct packed {
    logic [1:0]  kind;
    logic [1:0]  size;
    logic [4:0]  dest;
    logic [31:0] a;
    logic [31:0] dv;
    logic        be;
    logic        ee;
    logic        cd;
    logic        ci;
    logic        cb;
    logic        stb;
    logic [11:0] esr;
    logic [31:0] ear;
    logic        dz;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{2'd1,2'd2,5'd3, 32'h1004,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h000,32'h0,   1'b0,4'd4},  // R4 word aligned
    '{2'd1,2'd1,5'd3, 32'h1002,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h000,32'h0,   1'b0,4'd4},  // R4 half aligned
    '{2'd1,2'd0,5'd3, 32'h1003,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h000,32'h0,   1'b0,4'd4},  // R4 byte any
    '{2'd2,2'd1,5'd7, 32'h1101,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h4E1,32'h1101,1'b0,4'd5},  // R5 store half
    '{2'd1,2'd2,5'd31,32'h1202,32'd1,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,12'hBE1,32'h1202,1'b0,4'd6},  // R6 ee off
    '{2'd1,2'd2,5'd0, 32'h0FFC,32'd1,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b1,12'h007,32'h0FFC,1'b0,4'd7},  // R7 below
    '{2'd2,2'd2,5'd0, 32'h2000,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h007,32'h2000,1'b0,4'd7},  // R7 above
    '{2'd1,2'd2,5'd0, 32'h1FFC,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h007,32'h2000,1'b0,4'd7},  // R7 inside top
    '{2'd2,2'd0,5'd0, 32'h1000,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h007,32'h2000,1'b0,4'd7},  // R7 low bound
    '{2'd0,2'd0,5'd0, 32'h0,   32'd0,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h005,32'h2000,1'b1,4'd2},  // R2 raise
    '{2'd1,2'd2,5'd0, 32'h1008,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h005,32'h2000,1'b1,4'd2},  // R2 sticky
    '{2'd0,2'd0,5'd0, 32'h0,   32'd0,1'b0,1'b1,1'b0,1'b1,1'b1, 1'b0,12'h005,32'h2000,1'b1,4'd2},  // R2 cfg off
    '{2'd0,2'd0,5'd0, 32'h0,   32'd7,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h005,32'h2000,1'b0,4'd3},  // R3 clear
    '{2'd0,2'd0,5'd0, 32'h0,   32'd0,1'b0,1'b0,1'b1,1'b1,1'b1, 1'b0,12'h005,32'h2000,1'b1,4'd2},  // R2 ee off
    '{2'd3,2'd2,5'd0, 32'h3000,32'd1,1'b1,1'b0,1'b1,1'b1,1'b1, 1'b0,12'h005,32'h2000,1'b1,4'd8},  // R8 fetch
    '{2'd3,2'd2,5'd0, 32'h3004,32'd1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h003,32'h3004,1'b1,4'd9},  // R9 ibus
    '{2'd1,2'd2,5'd0, 32'h3008,32'd1,1'b1,1'b1,1'b1,1'b1,1'b0, 1'b0,12'h003,32'h3008,1'b1,4'd9},  // R9 dbus cfg off
    '{2'd2,2'd1,5'd0, 32'h0F01,32'd1,1'b1,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h004,32'h0F01,1'b1,4'd10}, // R10 bus first
    '{2'd1,2'd2,5'd2, 32'h0F02,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b1,12'h841,32'h0F02,1'b1,4'd10}, // R10 align>stack
    '{2'd2,2'd2,5'd0, 32'h0F03,32'd1,1'b1,1'b0,1'b1,1'b1,1'b1, 1'b0,12'h841,32'h0F02,1'b1,4'd8},  // R8 masks rest
    '{2'd3,2'd2,5'd0, 32'h0003,32'd1,1'b0,1'b1,1'b1,1'b1,1'b1, 1'b0,12'h841,32'h0F02,1'b1,4'd4}   // R4 fetch free
  };

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic stb, input logic [31:0] e,
                           input logic [31:0] a, input logic dz);
    check({req, " strobe"}, {31'd0, exc_strobe}, {31'd0, stb});
    check({req, " esr"}, esr, e);
    check({req, " ear"}, ear, a);
    check({req, " div_zero"}, {31'd0, div_zero}, {31'd0, dz});
  endtask

  task automatic idle_cycle();
    @(negedge clk);
    op_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  initial begin
    rst_n = 1'b0; op_valid = 1'b0; op_kind = 2'd0; addr = '0; divisor = '0;
    acc_size = 2'd0; dest_reg = '0; stk_lo = 32'h1000; stk_hi = 32'h1FFF;
    bus_err = 1'b0; msr_ee = 1'b0; cfg_div_exc = 1'b0; cfg_ibus_exc = 1'b0; cfg_dbus_exc = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check_all("R1 reset", 1'b0, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      op_valid = 1'b1;
      op_kind = VEC[i].kind; acc_size = VEC[i].size; dest_reg = VEC[i].dest;
      addr = VEC[i].a; divisor = VEC[i].dv; bus_err = VEC[i].be; msr_ee = VEC[i].ee;
      cfg_div_exc = VEC[i].cd; cfg_ibus_exc = VEC[i].ci; cfg_dbus_exc = VEC[i].cb;
      @(posedge clk);
      #1;
      check_all($sformatf("R%0d vec %0d", VEC[i].req, i), VEC[i].stb,
                {20'd0, VEC[i].esr}, VEC[i].ear, VEC[i].dz);
      idle_cycle();
      check($sformatf("R11 pulse end vec %0d", i), {31'd0, exc_strobe}, 32'd0);
    end

    // R11: garbage inputs with op_valid low change nothing
    @(negedge clk);
    op_valid = 1'b0; op_kind = 2'd2; acc_size = 2'd2; addr = 32'h0000_0001;
    bus_err = 1'b1; msr_ee = 1'b1; divisor = '0;
    @(posedge clk);
    #1;
    check_all("R11 idle", 1'b0, 32'h841, 32'h0F02, 1'b1);

    // R5: word store, misaligned, bits 10 and 11 both set
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'd2; acc_size = 2'd2; dest_reg = 5'd16;
    addr = 32'h1801; bus_err = 1'b0; msr_ee = 1'b1;
    @(posedge clk);
    #1;
    check_all("R5 word store", 1'b1, 32'hE01, 32'h1801, 1'b1);
    idle_cycle();
    check("R11 one cycle", {31'd0, exc_strobe}, 32'd0);

    // R1: reset mid-run clears everything
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    #1;
    check_all("R1 mid reset", 1'b0, 32'h0, 32'h0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule